// File: doc/BRIEF.md
# SDRAM Column Burst Data Engine

This block is the column-access core of a small synchronous DRAM model with two banks of 16-bit words. A READ or WRITE command carries a bank and a starting column. The block then steps an internal column counter once per clock for the configured burst length. Read words leave on a registered output after the configured CAS latency. Write words are taken from the data input on every beat, starting with the command cycle itself. Each of the two byte lanes has its own mask input, and a mask blocks its lane in the same cycle it is sampled.

A small mode setting holds the CAS latency (2 or 3), the burst length (1, 2, 4 or 8) and a flag for burst-read/single-write operation. When the flag is set, every WRITE stores one word, while READs still return a full burst. Masking never stalls the counter, so a masked beat is dropped rather than moved later. A new command issued during a burst cuts the running burst short. Read words that are already in the latency pipeline still come out.

The data paths are unconditional streams. Write data is sampled on every write beat, `rd_valid` qualifies each read word, and neither side has back-pressure. A consumer must take each read word in the cycle in which it is presented.

Top module: `sdram_burst_core`

## Requirements
- R1: After reset `rd_valid` is low and the mode is CAS latency 2, burst length 4, normal writes.
- R2: A READ sampled at clock edge n drives `rd_valid` high with the word of beat k, from the edge that ends cycle n+CL-1+k, for k = 0..BL-1, and drives `rd_valid` low in the cycle before and in the cycle after that window.
- R3: Beat k of a burst that starts at column C uses column (C with its low log2(BL) bits replaced by (C+k) mod BL), so the burst wraps inside the aligned block of BL columns.
- R4: In normal mode a WRITE stores BL words. Beat 0 takes `wr_data` in the command cycle, and beat k takes it k cycles later.
- R5: On a write beat, `wr_mask[1]` high keeps bits 15:8 of the addressed word unchanged, and `wr_mask[0]` high keeps bits 7:0 unchanged. Each lane is controlled only by its own bit, and a lane accepts data again on the first beat its bit is low.
- R6: A masked beat still advances the column counter, so the data of the next beat goes to the next column in the R3 order.
- R7: With the single-write flag set, a WRITE stores only the word of beat 0, and data driven in the following BL-1 cycles is not stored. READs still return BL words.
- R8: CAS latency codes 2 and 3 both work as in R2, with or without the single-write flag.
- R9: A READ or WRITE sampled during an active burst ends that burst, and the new burst's beat 0 happens at the edge that samples the new command. Read words already fetched still appear at their latency.
- R10: A mode load is ignored while a command is present, a burst is active or read words are pending. A CAS latency code other than 2 or 3 leaves the latency unchanged. A burst-length code above 3 (codes 0..3 mean 1, 2, 4 and 8 beats) leaves the length unchanged.
- R11: `wr_mask` and `wr_data` have no effect on `rd_data` or `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_bank | input | 1 | Bank select |
| cmd_col | input | 4 | Starting column |
| mode_load | input | 1 | Load the mode fields below |
| mode_cl | input | 2 | CAS latency code (2 or 3 accepted) |
| mode_bl | input | 3 | Burst-length code, 0..3 gives 1, 2, 4, 8 beats |
| mode_single | input | 1 | Burst-read/single-write flag |
| wr_data | input | 16 | Write word of the current beat |
| wr_mask | input | 2 | Per-lane write block: bit 1 bits 15:8, bit 0 bits 7:0 |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | 16 | Read word |

## Verification
The assertions assume that the mode is changed only through `mode_load`, and that the latency in effect for a read word is the latency in force when the word's READ was sampled. The block guarantees this itself, because a load is refused while any read word is still in the pipeline. The stimulus waits until the pipeline has drained before every intended mode load. It raises `mode_load` during a busy period only in the deliberate test of R10. Commands and data are driven on the falling edge, so every value is stable around the sampling edge. Both masks are held high during reads and idle cycles, so a write burst left running by the stimulus cannot store anything.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int CL_MAX = 3;
  localparam int BL_MAX = 8;
  localparam int BEAT_W = $clog2(BL_MAX + 1);

  typedef struct packed {
    logic [1:0]        cl;
    logic [BEAT_W-1:0] bl;
    logic              single;
  } mode_cfg_t;

  function automatic logic cl_code_ok(input logic [1:0] code);
    return code >= 2'd2;
  endfunction

  function automatic logic bl_code_ok(input logic [2:0] code);
    return code <= 3'd3;
  endfunction

  function automatic logic [BEAT_W-1:0] bl_beats(input logic [2:0] code);
    return BEAT_W'(1) << code[1:0];
  endfunction
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       busy,
  input  logic [1:0] cl_code,
  input  logic [2:0] bl_code,
  input  logic       single_in,
  output mode_cfg_t  cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.cl     <= 2'd2;
      cfg.bl     <= BEAT_W'(4);
      cfg.single <= 1'b0;
    end else if (load && !busy) begin
      if (cl_code_ok(cl_code)) cfg.cl <= cl_code;
      if (bl_code_ok(bl_code)) cfg.bl <= bl_beats(bl_code);
      cfg.single <= single_in;
    end
  end
endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  mode_cfg_t         cfg,
  output logic              beat_en,
  output logic              beat_wr,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              active,
  output logic [COL_W-1:0]  col_state
);
  logic              act_q, wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [BEAT_W-1:0] rem_q, start_rem;

  // Increment only the low bits covered by the burst length.
  function automatic logic [COL_W-1:0] wrap_next(input logic [COL_W-1:0] c,
                                                 input logic [BEAT_W-1:0] bl);
    logic [COL_W-1:0] m;
    m = COL_W'(bl - BEAT_W'(1));
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  always_comb begin
    beat_en   = cmd_valid | act_q;
    beat_wr   = cmd_valid ? cmd_write : wr_q;
    beat_bank = cmd_valid ? cmd_bank  : bank_q;
    beat_col  = cmd_valid ? cmd_col   : col_q;
    start_rem = (cmd_write && cfg.single) ? '0 : cfg.bl - BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      rem_q  <= '0;
    end else if (cmd_valid) begin
      act_q  <= start_rem != '0;
      wr_q   <= cmd_write;
      bank_q <= cmd_bank;
      col_q  <= wrap_next(cmd_col, cfg.bl);
      rem_q  <= start_rem;
    end else if (act_q) begin
      act_q  <= rem_q > BEAT_W'(1);
      col_q  <= wrap_next(col_q, cfg.bl);
      rem_q  <= rem_q - BEAT_W'(1);
    end
  end

  assign active    = act_q;
  assign col_state = col_q;
endmodule

// File: rtl/sdram_bank_array.sv
module sdram_bank_array #(
  parameter int NBANKS = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        en,
  input  logic                        wr,
  input  logic [$clog2(NBANKS)-1:0]   bank,
  input  logic [COL_W-1:0]            col,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [DATA_W/8-1:0]         mask,
  output logic [DATA_W-1:0]           rdata,
  output logic [DATA_W/8-1:0]         lane_we
);
  localparam int LANES  = DATA_W / 8;
  localparam int ADDR_W = $clog2(NBANKS) + COL_W;
  localparam int WORDS  = NBANKS << COL_W;

  logic [ADDR_W-1:0] addr;
  assign addr = {bank, col};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    assign lane_we[g] = en & wr & ~mask[g];
    always_ff @(posedge clk) begin
      if (lane_we[g]) lane_mem[addr] <= wdata[g*8 +: 8];
    end
    assign rdata[g*8 +: 8] = lane_mem[addr];
  end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
  parameter int DATA_W = 16,
  parameter int CL_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              pending
);
  localparam int SEL_W = $clog2(CL_MAX);

  logic [CL_MAX-1:0] v_q;
  logic [DATA_W-1:0] d_q [CL_MAX];
  logic [SEL_W-1:0]  tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[CL_MAX-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_data;
    for (int i = 1; i < CL_MAX; i++) d_q[i] <= d_q[i-1];
  end

  assign tap       = SEL_W'(cl - 2'd1);
  assign out_valid = v_q[tap];
  assign out_data  = d_q[tap];
  assign pending   = |v_q;
endmodule

// File: rtl/sdram_burst_core.sv
module sdram_burst_core
  import sdram_burst_pkg::*;
#(
  parameter int NBANKS = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic                      cmd_write,
  input  logic [$clog2(NBANKS)-1:0] cmd_bank,
  input  logic [COL_W-1:0]          cmd_col,
  input  logic                      mode_load,
  input  logic [1:0]                mode_cl,
  input  logic [2:0]                mode_bl,
  input  logic                      mode_single,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [DATA_W/8-1:0]       wr_mask,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int LANES  = DATA_W / 8;

  mode_cfg_t         cfg;
  logic [1:0]        cfg_cl;
  logic [BEAT_W-1:0] cfg_bl;
  logic              cfg_single;
  logic              busy, pipe_pending, eng_active, rd_beat;
  logic              beat_en, beat_wr;
  logic [BANK_W-1:0] beat_bank;
  logic [COL_W-1:0]  beat_col, eng_col;
  logic [DATA_W-1:0] arr_rdata;
  logic [LANES-1:0]  lane_we;

  assign cfg_cl     = cfg.cl;
  assign cfg_bl     = cfg.bl;
  assign cfg_single = cfg.single;
  assign busy       = cmd_valid | eng_active | pipe_pending;
  assign rd_beat    = beat_en & ~beat_wr;

  sdram_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .busy(busy),
    .cl_code(mode_cl), .bl_code(mode_bl), .single_in(mode_single), .cfg(cfg)
  );

  sdram_burst_ctr #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cfg(cfg),
    .beat_en(beat_en), .beat_wr(beat_wr), .beat_bank(beat_bank),
    .beat_col(beat_col), .active(eng_active), .col_state(eng_col)
  );

  sdram_bank_array #(.NBANKS(NBANKS), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .en(beat_en), .wr(beat_wr), .bank(beat_bank), .col(beat_col),
    .wdata(wr_data), .mask(wr_mask), .rdata(arr_rdata), .lane_we(lane_we)
  );

  sdram_read_pipe #(.DATA_W(DATA_W), .CL_MAX(CL_MAX)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(rd_beat), .in_data(arr_rdata),
    .cl(cfg_cl), .out_valid(rd_valid), .out_data(rd_data), .pending(pipe_pending)
  );
endmodule

// File: rtl/sdram_burst_core_chk.sv
module sdram_burst_core_chk #(
  parameter int COL_W  = 4,
  parameter int LANES  = 2,
  parameter int BEAT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [LANES-1:0]  wr_mask,
  input logic              rd_valid,
  input logic              busy,
  input logic [1:0]        cfg_cl,
  input logic [BEAT_W-1:0] cfg_bl,
  input logic              cfg_single,
  input logic              eng_active,
  input logic [COL_W-1:0]  eng_col,
  input logic              rd_beat,
  input logic [LANES-1:0]  lane_we
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((cfg_cl == 2'd2) ? $past(rd_beat, 2) : $past(rd_beat, 3)));

  // R5
  upper_lane_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[LANES-1] |-> !wr_mask[LANES-1]);

  // R5
  lower_lane_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[0] |-> !wr_mask[0]);

  // R6
  col_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_active && !cmd_valid) |=> (eng_col != $past(eng_col)));

  // R7
  single_write_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cfg_single) |=> !eng_active);

  // R10
  mode_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_cl) && $stable(cfg_bl) && $stable(cfg_single)));

  // R10
  mode_codes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cl >= 2'd2) && ($countones(cfg_bl) == 1));
endmodule

bind sdram_burst_core sdram_burst_core_chk #(
  .COL_W(COL_W), .LANES(LANES), .BEAT_W(sdram_burst_pkg::BEAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .wr_mask(wr_mask), .rd_valid(rd_valid), .busy(busy), .cfg_cl(cfg_cl),
  .cfg_bl(cfg_bl), .cfg_single(cfg_single), .eng_active(eng_active),
  .eng_col(eng_col), .rd_beat(rd_beat), .lane_we(lane_we)
);

// File: tb/test_sdram_burst_core.sv
`timescale 1ns/1ps
module test_sdram_burst_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [0:0]  cmd_bank = '0;
  logic [3:0]  cmd_col = '0;
  logic        mode_load = 1'b0;
  logic [1:0]  mode_cl = 2'd2;
  logic [2:0]  mode_bl = 3'd2;
  logic        mode_single = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_mask = 2'b11;
  logic        rd_valid;
  logic [15:0] rd_data;

  int total = 0, fails = 0;
  bit done = 0;
  int exp_cl = 2, exp_bl = 4, exp_sw = 0;
  logic [15:0] model [2][16];

  always #2 clk = ~clk;

  sdram_burst_core i_sdram_burst_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .mode_load(mode_load),
    .mode_cl(mode_cl), .mode_bl(mode_bl), .mode_single(mode_single),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R3 order computed arithmetically
  function automatic int wrap(input int col, input int k);
    int m;
    m = exp_bl - 1;
    return ((col & ~m) | ((col + k) & m)) & 15;
  endfunction

  function automatic logic [15:0] wdat(input int seed, input int k);
    return 16'((seed * 2837) ^ (k * 4951) ^ 23040);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Applies the R10 code rules to the expected mode
  task automatic set_mode(input int cl, input int blc, input int sw);
    idle(3);
    mode_load = 1'b1; mode_cl = 2'(cl); mode_bl = 3'(blc); mode_single = sw[0];
    if (cl == 2 || cl == 3) exp_cl = cl;
    if (blc <= 3) exp_bl = 1 << blc;
    exp_sw = sw;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // Write beats; extra driven beats past the burst must not be stored (R7)
  task automatic wr_burst(input int bank, input int col, input int seed,
                          input int usemask, input int ndrive);
    int beats;
    beats = exp_sw ? 1 : exp_bl;
    for (int k = 0; k < ndrive; k++) begin
      cmd_valid = (k == 0); cmd_write = 1'b1;
      cmd_bank = 1'(bank); cmd_col = 4'(col);
      wr_data = wdat(seed, k);
      wr_mask = usemask ? 2'(k + seed) : 2'b00;
      if (k < beats) begin
        if (!wr_mask[1]) model[bank][wrap(col, k)][15:8] = wr_data[15:8];
        if (!wr_mask[0]) model[bank][wrap(col, k)][7:0]  = wr_data[7:0];
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0; wr_mask = 2'b11;
  endtask

  // Reads with both masks high and junk data driven (R11)
  task automatic rd_burst(input int bank, input int col, input string tag);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 1'(bank); cmd_col = 4'(col);
    wr_mask = 2'b11; wr_data = 16'hDEAD;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = 16'h0;
    for (int i = 1; i <= exp_cl + exp_bl; i++) begin
      if (i < exp_cl)
        chk({tag, " R2 quiet before latency"}, 32'(rd_valid), 32'(0));
      else if (i < exp_cl + exp_bl)
        chk({tag, " data"}, 32'({rd_valid, rd_data}),
            32'({1'b1, model[bank][wrap(col, i - exp_cl)]}));
      else
        chk({tag, " R2 quiet after burst"}, 32'(rd_valid), 32'(0));
      if (i < exp_cl + exp_bl) @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rd_valid after reset", 32'(rd_valid), 32'(0));

    // R1 defaults: fill with 4-beat writes, then read a wrapping burst at CL 2
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c += 4) wr_burst(b, c, b * 16 + c + 1, 0, 4);
    idle(2);
    rd_burst(0, 6, "R1 R3 default mode");

    // R3 R4 R5 R6 R7 R8 sweep over latency, length and write mode
    for (int cl = 2; cl <= 3; cl++)
      for (int blc = 0; blc <= 3; blc++)
        for (int sw = 0; sw <= 1; sw++) begin
          int col, bank;
          set_mode(cl, blc, sw);
          col  = (cl * 3 + blc * 5 + sw * 7) % 16;
          bank = (blc + sw) % 2;
          wr_burst(bank, col, cl * 8 + blc * 2 + sw, 1, exp_bl);
          idle(2);
          rd_burst(bank, col, "R3 R4 R5 R6 R7 R8 sweep");
          rd_burst(bank, col ^ 1, "R3 R8 neighbour");
        end

    // R9 read cut by a read at CL 3, BL 8
    set_mode(3, 3, 0);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 1'b0; cmd_col = 4'd2; wr_mask = 2'b11;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bank = 1'b1; cmd_col = 4'd9;
    @(negedge clk); cmd_valid = 1'b0;
    for (int i = 3; i <= 13; i++) begin
      if (i < 5)
        chk("R9 first burst cut", 32'({rd_valid, rd_data}), 32'({1'b1, model[0][wrap(2, i - 3)]}));
      else if (i < 13)
        chk("R9 second burst", 32'({rd_valid, rd_data}), 32'({1'b1, model[1][wrap(9, i - 5)]}));
      else
        chk("R9 end of bursts", 32'(rd_valid), 32'(0));
      if (i < 13) @(negedge clk);
    end

    // R9 write cut after three beats by a write into the upper block
    set_mode(2, 3, 0);
    wr_burst(0, 0, 40, 0, 3);
    wr_burst(0, 12, 41, 0, 8);
    idle(2);
    rd_burst(0, 0, "R9 write cut lower block");
    rd_burst(0, 8, "R9 write cut upper block");

    // R10 load during an active burst is ignored
    set_mode(2, 2, 0);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank = 1'b1; cmd_col = 4'd4;
    @(negedge clk);
    cmd_valid = 1'b0; mode_load = 1'b1; mode_cl = 2'd3; mode_bl = 3'd3; mode_single = 1'b1;
    @(negedge clk);
    mode_load = 1'b0;
    idle(6);
    rd_burst(1, 5, "R10 busy load ignored");
    wr_burst(1, 5, 77, 0, 4);
    idle(2);
    rd_burst(1, 4, "R10 write still bursts");

    // R10 unsupported codes keep their field
    set_mode(1, 3, 0);
    rd_burst(0, 3, "R10 bad latency code held");
    set_mode(3, 6, 0);
    rd_burst(1, 10, "R10 bad length code held");

    // R5 independent lanes at BL 4: alternate masks per beat
    set_mode(2, 2, 0);
    wr_burst(0, 4, 2, 1, 4);
    idle(2);
    rd_burst(0, 4, "R5 R6 lane masks");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule